// File: doc/BRIEF.md
# Signed-Digit Fraction Normalizer

This block sits after a multi-operand adder in a most-significant-digit-first radix-2 datapath. The adder's result stream carries a few integer-position digits ahead of the binary point. Every digit is in borrow-save form: a positive line and a negative line, and the digit value is positive minus negative. When the operands were scaled so that the true value has magnitude below one, the redundant integer part can still be nonzero. The block rewrites such a stream into a purely fractional signed-digit number of the same value. Integer-position digits come out as zero.

The block adds no on-line delay. Each output digit is formed combinationally from the current input digit and a small amount of state that the digits already seen have built up. A frame is a run of cycles with the valid line high, and its first `INT_DIGITS` digits are integer positions. If the integer prefix cannot be absorbed into the fraction, the rest of the frame is forced to the nearest representable bound.

A control module tracks the integer prefix and the state of the frame, and sends a small strobe struct to a datapath module that forms the output digit.

Top module: `sd_fraction_normalizer`

## Requirements
- R1: Input digits decode as (1,0) = +1, (0,1) = -1, and (0,0) or (1,1) = 0 on (positive line, negative line). Output digits use (1,0) = +1, (0,1) = -1 and (0,0) = 0, and the output is never (1,1).
- R2: A frame is a run of cycles with `inValid` high, most significant digit first, and its first `INT_DIGITS` digits are integer positions. One low cycle of `inValid` clears all frame state, including when a frame is cut short. `outValid` equals `inValid` in the same cycle.
- R3: Every integer-position output digit is 0.
- R4: Each output digit appears in the same cycle as the input digit it belongs to, with no added latency.
- R5: When the integer prefix has value 0, every fraction digit is reproduced with its own value.
- R6: When the integer prefix has value +1 (a +1 followed only by -1 digits, possibly after leading zeros) and the first nonzero fraction digit is -1, every fraction digit up to and including that one becomes +1. Later digits are reproduced.
- R7: When the integer prefix has value -1 (a -1 followed only by +1 digits) and the first nonzero fraction digit is +1, every fraction digit up to and including that one becomes -1. Later digits are reproduced.
- R8: Positive overflow makes every remaining fraction digit of the frame +1. Positive overflow means an integer prefix of +2 or more, a +1 prefix whose first nonzero fraction digit is +1, or a +1 prefix with an all-zero fraction.
- R9: Negative overflow, which mirrors R8, makes every remaining fraction digit of the frame -1.
- R10: For any frame, the value of the output fraction equals the input value when its magnitude is below one. Otherwise it equals the nearest bound, plus or minus (1 - 2^-F), where F is the number of fraction digits.
- R11: While `inValid` is low, both output digit lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | High while frame digits are present |
| inPos | input | 1 | Positive line of the input digit |
| inNeg | input | 1 | Negative line of the input digit |
| outValid | output | 1 | Frame control aligned with the output digit |
| outPos | output | 1 | Positive line of the output digit |
| outNeg | output | 1 | Negative line of the output digit |

## Verification
The hardest situation to reach is a pending prefix that resolves late: a +1 or -1 integer part followed by a long run of zero fraction digits, which ends in the opposite-sign digit (a rewrite), the same-sign digit (an overflow) or no nonzero digit at all (an exact ±1 that must saturate). Directed table entries place the resolving digit at different depths and also use the (1,1) form of zero. A frame cut short in a saturated state shows that one idle cycle clears the state. Random frames then compare the output value against the clamped input value across many prefix and fraction mixes.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  typedef enum logic [2:0] {
    ST_NEUTRAL,
    ST_PEND_POS,
    ST_PEND_NEG,
    ST_SAT_POS,
    ST_SAT_NEG,
    ST_PASS
  } nrmState_e;

  // strobes from control to datapath, all already qualified by inValid
  typedef struct packed {
    logic intSlot;   // current digit is an integer position
    logic forcePos;  // emit +1
    logic forceNeg;  // emit -1
    logic copyIn;    // reproduce the input digit
  } nrmStrobe_t;

endpackage

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
#(
  parameter int INT_DIGITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inPos,
  input  logic       inNeg,
  output nrmStrobe_t strb
);

  localparam int CNT_W = $clog2(INT_DIGITS + 1);
  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_DIGITS);

  nrmState_e state, stateNxt;
  logic [CNT_W-1:0] intCnt;
  logic isPlus, isMinus, isZero, inInt;

  assign isPlus  = inPos & ~inNeg;
  assign isMinus = inNeg & ~inPos;
  assign isZero  = ~(isPlus | isMinus);
  assign inInt   = inValid && (intCnt < INT_LAST);

  always_comb begin
    stateNxt = state;
    if (!inValid) begin
      stateNxt = ST_NEUTRAL;
    end else if (inInt) begin
      case (state)
        ST_NEUTRAL:  if (isPlus) stateNxt = ST_PEND_POS;
                     else if (isMinus) stateNxt = ST_PEND_NEG;
        ST_PEND_POS: if (!isMinus) stateNxt = ST_SAT_POS;
        ST_PEND_NEG: if (!isPlus) stateNxt = ST_SAT_NEG;
        default:     stateNxt = state;
      endcase
    end else begin
      case (state)
        ST_NEUTRAL:  stateNxt = ST_PASS;
        ST_PEND_POS: if (isMinus) stateNxt = ST_PASS;
                     else if (isPlus) stateNxt = ST_SAT_POS;
        ST_PEND_NEG: if (isPlus) stateNxt = ST_PASS;
                     else if (isMinus) stateNxt = ST_SAT_NEG;
        default:     stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_NEUTRAL;
      intCnt <= '0;
    end else begin
      state <= stateNxt;
      if (!inValid) intCnt <= '0;
      else if (intCnt < INT_LAST) intCnt <= intCnt + 1'b1;
    end
  end

  always_comb begin
    strb.intSlot  = inInt;
    strb.forcePos = inValid && !inInt && (state == ST_PEND_POS || state == ST_SAT_POS);
    strb.forceNeg = inValid && !inInt && (state == ST_PEND_NEG || state == ST_SAT_NEG);
    strb.copyIn   = inValid && !inInt && (state == ST_NEUTRAL || state == ST_PASS);
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (state == ST_NEUTRAL && intCnt == '0)); // R2
  AST_SAT_POS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && state == ST_SAT_POS) |=> state == ST_SAT_POS); // R8
  AST_SAT_NEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && state == ST_SAT_NEG) |=> state == ST_SAT_NEG); // R9
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && state == ST_PASS) |=> state == ST_PASS); // R5
  AST_ZERO_PREFIX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inInt && state == ST_NEUTRAL) |=> state == ST_PASS || !inValid); // R5

endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
  import nrm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inPos,
  input  logic       inNeg,
  input  nrmStrobe_t strb,
  output logic       outValid,
  output logic       outPos,
  output logic       outNeg
);

  logic isPlus, isMinus;

  assign isPlus   = inPos & ~inNeg;
  assign isMinus  = inNeg & ~inPos;
  assign outValid = inValid;
  assign outPos   = strb.forcePos | (strb.copyIn & isPlus);
  assign outNeg   = strb.forceNeg | (strb.copyIn & isMinus);

  AST_INT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strb.intSlot |-> (!outPos && !outNeg)); // R3
  AST_OUT_CANON: assert property (@(posedge clk) disable iff (!rstN)
    !(outPos && outNeg)); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!outPos && !outNeg)); // R11

endmodule

// File: rtl/sd_fraction_normalizer.sv
module sd_fraction_normalizer
  import nrm_pkg::*;
#(
  parameter int INT_DIGITS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inPos,
  input  logic inNeg,
  output logic outValid,
  output logic outPos,
  output logic outNeg
);

  nrmStrobe_t strb;

  nrm_ctrl #(.INT_DIGITS(INT_DIGITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inPos(inPos), .inNeg(inNeg), .strb(strb)
  );

  nrm_datapath u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inPos(inPos), .inNeg(inNeg), .strb(strb),
    .outValid(outValid), .outPos(outPos), .outNeg(outNeg)
  );

endmodule

// File: tb/test_sd_fraction_normalizer.sv
module test_sd_fraction_normalizer;

  localparam int INTD = 2;
  localparam int FRAC = 8;
  localparam int D    = INTD + FRAC;
  localparam int NV   = 12;
  localparam logic [1:0] P = 2'b10, N = 2'b01, Z = 2'b00, W = 2'b11;

  localparam logic [2*D-1:0] STIM [NV] = '{
    {Z,Z,P,N,Z,P,Z,Z,N,P},
    {Z,P,Z,Z,N,P,Z,N,Z,P},
    {P,N,Z,N,Z,Z,Z,Z,Z,P},
    {N,P,Z,Z,Z,P,N,Z,Z,Z},
    {P,Z,N,N,N,N,N,N,N,N},
    {Z,P,Z,P,N,N,N,N,N,N},
    {Z,N,Z,Z,Z,Z,Z,Z,Z,Z},
    {N,P,N,P,Z,Z,Z,Z,Z,Z},
    {W,W,W,P,W,N,W,W,W,W},
    {W,P,W,N,P,P,Z,Z,Z,Z},
    {N,P,Z,P,Z,N,Z,Z,Z,P},
    {N,N,P,P,P,P,P,P,P,P}
  };
  localparam logic [2*FRAC-1:0] EXPF [NV] = '{
    {P,N,Z,P,Z,Z,N,P},
    {P,P,P,P,Z,N,Z,P},
    {P,P,Z,Z,Z,Z,Z,P},
    {N,N,N,N,N,Z,Z,Z},
    {8{P}},
    {8{P}},
    {8{N}},
    {8{N}},
    {Z,P,Z,N,Z,Z,Z,Z},
    {P,P,P,P,Z,Z,Z,Z},
    {N,N,Z,N,Z,Z,Z,P},
    {8{N}}
  };
  localparam string TAG [NV] = '{"R5","R6","R6","R7","R8","R8","R9","R9","R1","R1","R7","R9"};

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inPos = 1'b0, inNeg = 1'b0;
  logic outValid, outPos, outNeg;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sd_fraction_normalizer #(.INT_DIGITS(INTD)) i_sd_fraction_normalizer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPos(inPos), .inNeg(inNeg),
    .outValid(outValid), .outPos(outPos), .outNeg(outNeg)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dval(input logic [1:0] c);
    return (c == P) ? 1 : (c == N) ? -1 : 0;
  endfunction

  // drive one frame, capture every output digit; alignOk reports outValid and (1,1)
  task automatic runFrame(input logic [2*D-1:0] stim, output logic [2*D-1:0] got, output bit alignOk);
    alignOk = 1;
    for (int i = 0; i < D; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      {inPos, inNeg} = stim[2*(D-1-i) +: 2];
      #2;
      got[2*(D-1-i) +: 2] = {outPos, outNeg};
      if (outValid !== 1'b1 || (outPos && outNeg)) alignOk = 0;
    end
    @(negedge clk);
    inValid = 1'b0; inPos = 1'b0; inNeg = 1'b0;
    #2;
    if (outValid !== 1'b0 || outPos || outNeg) alignOk = 0;
  endtask

  initial begin : main
    logic [2*D-1:0] got;
    bit okA;
    repeat (3) @(negedge clk);
    #2;
    check(outValid === 1'b0 && outPos === 1'b0 && outNeg === 1'b0, "R11 reset", {outValid, outPos, outNeg}, 0);
    @(negedge clk); rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      runFrame(STIM[v], got, okA);
      check(got[2*FRAC-1:0] == EXPF[v], TAG[v], got[2*FRAC-1:0], EXPF[v]);
      check(got[2*D-1:2*FRAC] == '0, "R3", got[2*D-1:2*FRAC], 0);
      check(okA, "R2 R4 R11 alignment", okA, 1);
    end

    // frame cut short in a saturated state, then a zero-prefix frame
    @(negedge clk); inValid = 1'b1; {inPos, inNeg} = P;
    @(negedge clk); {inPos, inNeg} = Z;
    @(negedge clk); {inPos, inNeg} = P;
    @(negedge clk); inValid = 1'b0; {inPos, inNeg} = Z;
    runFrame(STIM[0], got, okA);
    check(got[2*FRAC-1:0] == EXPF[0], "R2 abort clear", got[2*FRAC-1:0], EXPF[0]);

    // random frames, value check against clamped input
    for (int f = 0; f < 300; f++) begin
      logic [2*D-1:0] s;
      int vin, vout, vexp, lim;
      bit okV;
      lim = (1 << FRAC) - 1;
      vin = 0;
      for (int i = 0; i < D; i++) begin
        s[2*(D-1-i) +: 2] = 2'($urandom_range(0, 3));
        if (f % 3 == 0 && i < INTD) s[2*(D-1-i) +: 2] = (i == 0) ? ((f % 2) ? P : N) : ((f % 2) ? N : P);
        vin += dval(s[2*(D-1-i) +: 2]) * (1 << (D - 1 - i));
      end
      runFrame(s, got, okA);
      vout = 0;
      for (int i = 0; i < FRAC; i++) vout += dval(got[2*(FRAC-1-i) +: 2]) * (1 << (FRAC - 1 - i));
      vexp = (vin > lim) ? lim : (vin < -lim) ? -lim : vin;
      okV = (vout == vexp) && (got[2*D-1:2*FRAC] == '0) && okA;
      check(okV, (vin > lim) ? "R8 R10" : (vin < -lim) ? "R9 R10" : "R10", vout, vexp);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule